// File: doc/BRIEF.md
# Prescaled Low-Width PWM Timer

This block generates one pulse-width-modulated output from a 24-bit up-counter. The counter advances on ticks from a prescaler that divides the block clock by a power of sixteen, capped at 2048. A period lasts the programmed period value plus one ticks. Each period opens with a "first phase" whose length in ticks comes from a low-width register. The rest of the period is the second phase. With the polarity bit clear, the first phase drives the output low and the second phase drives it high. Setting the polarity bit swaps the two levels.

Software reaches the block through a simple word-addressed register port. Writes take one cycle and reads are combinational. Changes to the low width are held in a shadow copy and take effect only at the next period boundary. The period register can be written only while the timer is stopped. Three events set sticky status bits: a rising output edge, a falling output edge and the counter wrap at the end of a period. Each status bit is cleared by writing 1 to it. A mask selects which status bits drive the single interrupt line.

Top module: `pwm_lowwidth_timer`

## Requirements
- R1: After reset the output and the interrupt are 0, and every register reads 0.
- R2: Control at 0x00 holds enable at bit 1, a stored mode bit at bit 2, polarity at bit 3 and the prescale code at bits [17:16]. Period at 0x04 and low width at 0x08 are 24 bits. Status at 0x10 and mask at 0x14 use bit 0 for rise, bit 1 for fall and bit 2 for wrap. Unused bits and unmapped offsets read 0.
- R3: The counter, read at 0x0C, steps once per prescaler tick. It returns to 0 after the tick on which it equals the period value. Prescale codes 0, 1, 2 and 3 give one tick every 1, 16, 256 and 2048 clocks.
- R4: While enabled, the output is at the first-phase level while counter < low width, and at the other level otherwise. The first-phase level is 0 with polarity 0 and 1 with polarity 1.
- R5: A low width of 0 gives no first phase. A low width greater than the period value holds the first-phase level for the whole period.
- R6: A low-width write made while running takes effect from the next period start. A write in the same cycle as the wrap applies only from the period after the next one.
- R7: Period writes while enable is 1 are ignored, and the running waveform keeps its old period.
- R8: While disabled, the output is 0 and the counter is 0. Enabling restarts counter and prescaler from 0, using the current low-width value from the first cycle.
- R9: Rise, fall and wrap events set their sticky status bits. Writing 1 clears a bit. An event in the same cycle as a clear of that bit leaves the bit set.
- R10: The interrupt is 1 exactly when some status bit is set and its mask bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the counting clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| pwm_out | output | 1 | PWM output |
| irq | output | 1 | Masked interrupt request |

## Verification
Two pairs of functions can land in the same cycle.

The first pair is a write-1-to-clear of the status register and a new event. The bench issues the clear so that its write edge coincides with the wrap tick. It then expects the wrap bit to survive while the older rise bit is gone. One cycle later the fresh fall bit must also appear.

The second pair is a low-width write and the period boundary. The bench writes the new width on the wrap edge itself. It then checks the output cycle by cycle: the old width must hold for one more whole period before the new one appears.

// File: rtl/pwm_lw_pkg.sv
package pwm_lw_pkg;

    localparam int CNT_W  = 24;
    localparam int PS_W   = 2;
    localparam int PRE_W  = 11;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int DIV_SHIFT = 4;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_PER  = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_LOW  = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_CNT  = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_STS  = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_MSK  = 8'h14;

    localparam int BIT_RUN   = 1;
    localparam int BIT_MODE  = 2;
    localparam int BIT_POL   = 3;
    localparam int BIT_PS_LO = 16;

    typedef struct packed {
        logic [PS_W-1:0] ps;
        logic            pol;
        logic            mode;
        logic            run;
    } ctrl_t;

    typedef struct packed {
        logic wrap;
        logic fall;
        logic rise;
    } evt_t;

    // Terminal value of the prescaler: steps of 2^4, top code capped at 2^PRE_W.
    function automatic logic [PRE_W-1:0] div_limit(input logic [PS_W-1:0] code);
        logic [PRE_W:0] d;
        if (code == {PS_W{1'b1}})
            d = {1'b1, {PRE_W{1'b0}}};
        else
            d = {{PRE_W{1'b0}}, 1'b1} << (DIV_SHIFT * int'(code));
        d = d - {{PRE_W{1'b0}}, 1'b1};
        return d[PRE_W-1:0];
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_word(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[BIT_RUN]  = c.run;
        w[BIT_MODE] = c.mode;
        w[BIT_POL]  = c.pol;
        w[BIT_PS_LO +: PS_W] = c.ps;
        return w;
    endfunction

endpackage

// File: rtl/pwm_lw_prescaler.sv
module pwm_lw_prescaler
    import pwm_lw_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic [PS_W-1:0] ps,
    output logic            tick
);
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] lim;

    assign lim  = div_limit(ps);
    assign tick = run && (pre_q == lim);

    always_ff @(posedge clk) begin
        if (rst || !run)
            pre_q <= '0;
        else if (tick)
            pre_q <= '0;
        else
            pre_q <= pre_q + 1'b1;
    end
endmodule

// File: rtl/pwm_lw_core.sv
module pwm_lw_core
    import pwm_lw_pkg::*;
#(
    parameter int CW = CNT_W
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          pol,
    input  logic          tick,
    input  logic [CW-1:0] period,
    input  logic [CW-1:0] low_width,
    output logic [CW-1:0] cnt,
    output logic          pwm,
    output evt_t          evt
);
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] act_low_q;
    logic          pwm_d_q;
    logic          period_end;
    logic          first_phase;

    assign period_end = run && tick && (cnt_q == period);

    // Shadow low width tracks the register while stopped, then only at wrap.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            act_low_q <= '0;
        end else if (!run) begin
            cnt_q     <= '0;
            act_low_q <= low_width;
        end else if (tick) begin
            if (period_end) begin
                cnt_q     <= '0;
                act_low_q <= low_width;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign first_phase = (cnt_q < act_low_q);
    assign pwm = run & (first_phase ? pol : ~pol);
    assign cnt = cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            pwm_d_q <= 1'b0;
        else
            pwm_d_q <= pwm;
    end

    assign evt.rise = pwm & ~pwm_d_q;
    assign evt.fall = ~pwm & pwm_d_q;
    assign evt.wrap = period_end;
endmodule

// File: rtl/pwm_lw_regs.sv
module pwm_lw_regs
    import pwm_lw_pkg::*;
#(
    parameter int CW = CNT_W
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CW-1:0]     cnt,
    input  evt_t              evt,
    output logic [DATA_W-1:0] rdata,
    output ctrl_t             ctrl,
    output logic [CW-1:0]     period,
    output logic [CW-1:0]     low_width,
    output evt_t              sts,
    output evt_t              mask
);
    localparam int PAD_W = DATA_W - CW;
    localparam int EV_W  = $bits(evt_t);

    ctrl_t         ctrl_q;
    logic [CW-1:0] per_q;
    logic [CW-1:0] low_q;
    evt_t          sts_q;
    evt_t          msk_q;
    evt_t          clr;
    logic          unused_hi;

    assign unused_hi = ^wdata[DATA_W-1:CW];

    assign clr = (wr_en && addr == OFS_STS) ? evt_t'(wdata[EV_W-1:0]) : evt_t'('0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            per_q  <= '0;
            low_q  <= '0;
            sts_q  <= '0;
            msk_q  <= '0;
        end else begin
            // New events win over a simultaneous clear.
            sts_q <= (sts_q & ~clr) | evt;
            if (wr_en) begin
                case (addr)
                    OFS_CTRL: begin
                        ctrl_q.run  <= wdata[BIT_RUN];
                        ctrl_q.mode <= wdata[BIT_MODE];
                        ctrl_q.pol  <= wdata[BIT_POL];
                        ctrl_q.ps   <= wdata[BIT_PS_LO +: PS_W];
                    end
                    OFS_PER: if (!ctrl_q.run) per_q <= wdata[CW-1:0];
                    OFS_LOW: low_q <= wdata[CW-1:0];
                    OFS_MSK: msk_q <= evt_t'(wdata[EV_W-1:0]);
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (addr)
            OFS_CTRL: rdata = ctrl_word(ctrl_q);
            OFS_PER:  rdata = {{PAD_W{1'b0}}, per_q};
            OFS_LOW:  rdata = {{PAD_W{1'b0}}, low_q};
            OFS_CNT:  rdata = {{PAD_W{1'b0}}, cnt};
            OFS_STS:  rdata = {{(DATA_W-EV_W){1'b0}}, sts_q};
            OFS_MSK:  rdata = {{(DATA_W-EV_W){1'b0}}, msk_q};
            default:  rdata = '0;
        endcase
    end

    assign ctrl      = ctrl_q;
    assign period    = per_q;
    assign low_width = low_q;
    assign sts       = sts_q;
    assign mask      = msk_q;
endmodule

// File: rtl/pwm_lowwidth_timer.sv
module pwm_lowwidth_timer
    import pwm_lw_pkg::*;
#(
    parameter int CW = CNT_W
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              pwm_out,
    output logic              irq
);
    ctrl_t         ctrl;
    logic [CW-1:0] period;
    logic [CW-1:0] low_width;
    logic [CW-1:0] cnt;
    evt_t          evt;
    evt_t          sts;
    evt_t          mask;
    logic          tick;
    logic          run;
    logic [2:0]    sts_v;
    logic [2:0]    mask_v;

    assign run    = ctrl.run;
    assign sts_v  = sts;
    assign mask_v = mask;

    pwm_lw_regs #(.CW(CW)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .cnt(cnt), .evt(evt), .rdata(rdata), .ctrl(ctrl), .period(period),
        .low_width(low_width), .sts(sts), .mask(mask)
    );

    pwm_lw_prescaler u_pre (
        .clk(clk), .rst(rst), .run(run), .ps(ctrl.ps), .tick(tick)
    );

    pwm_lw_core #(.CW(CW)) u_core (
        .clk(clk), .rst(rst), .run(run), .pol(ctrl.pol), .tick(tick),
        .period(period), .low_width(low_width), .cnt(cnt), .pwm(pwm_out),
        .evt(evt)
    );

    assign irq = |(sts_v & mask_v);
endmodule

// File: rtl/pwm_lowwidth_timer_chk.sv
module pwm_lowwidth_timer_chk #(
    parameter int CW = 24
)(
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic [7:0]    addr,
    input logic [31:0]   wdata,
    input logic          run,
    input logic [CW-1:0] period,
    input logic [CW-1:0] cnt,
    input logic          pwm_out,
    input logic [2:0]    sts_v,
    input logic [2:0]    mask_v,
    input logic          irq
);
    assert_off_low_R8: assert property (@(posedge clk) disable iff (rst)
        !run |-> !pwm_out);

    assert_off_cnt_R8: assert property (@(posedge clk) disable iff (rst)
        !run |=> cnt == '0);

    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
        run |-> cnt <= period);

    assert_period_hold_R7: assert property (@(posedge clk) disable iff (rst)
        run |=> $stable(period));

    assert_wrap_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (sts_v[2] && !(wr_en && addr == 8'h10 && wdata[2])) |=> sts_v[2]);

    assert_rise_flag_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(pwm_out) |=> sts_v[0]);

    assert_irq_masked_R10: assert property (@(posedge clk) disable iff (rst)
        (mask_v == 3'b000) |-> !irq);
endmodule

bind pwm_lowwidth_timer pwm_lowwidth_timer_chk #(.CW(CW)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .run(run), .period(period), .cnt(cnt), .pwm_out(pwm_out),
    .sts_v(sts_v), .mask_v(mask_v), .irq(irq)
);

// File: tb/pwm_lowwidth_timer_tb.sv
module pwm_lowwidth_timer_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_CTRL = 8'h00, A_PER = 8'h04, A_LOW = 8'h08,
                           A_CNT = 8'h0C, A_STS = 8'h10, A_MSK = 8'h14;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        pwm_out;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_lowwidth_timer u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pwm_out(pwm_out), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Call at a falling edge; returns at the falling edge after the write edge.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [7:0] a, input logic [31:0] exp);
        addr = a;
        #1;
        check(req, rdata, exp);
    endtask

    task automatic run_cfg(input int ps, input int per, input int low, input int pol, input int ncyc);
        int div;
        div = (ps == 3) ? 2048 : (1 << (4 * ps));
        wr(A_CTRL, 32'h0);
        wr(A_PER, per);
        wr(A_LOW, low);
        wr(A_CTRL, (ps << 16) | (pol << 3) | 32'h2);
        addr = A_CNT;
        for (int k = 0; k < ncyc; k++) begin
            int c;
            logic e;
            c = (k / div) % (per + 1);
            e = (c < low) ? pol[0] : !pol[0];
            #1;
            if (low == 0 || low > per)
                check("R5 edge-case width", {31'b0, pwm_out}, {31'b0, e});
            else
                check("R4 waveform", {31'b0, pwm_out}, {31'b0, e});
            check("R3 counter", rdata, c);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        #1;
        check("R1 pwm", {31'b0, pwm_out}, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);
        rd_check("R1 ctrl", A_CTRL, 0);
        rd_check("R1 period", A_PER, 0);
        rd_check("R1 low", A_LOW, 0);
        rd_check("R1 cnt", A_CNT, 0);
        rd_check("R1 sts", A_STS, 0);
        rd_check("R1 mask", A_MSK, 0);
        @(negedge clk);

        // R2 field placement and width
        wr(A_CTRL, 32'hFFFF_FFFD);
        rd_check("R2 ctrl", A_CTRL, 32'h0003_000C);
        wr(A_PER, 32'hFFFF_FFFF);
        rd_check("R2 period", A_PER, 32'h00FF_FFFF);
        wr(A_LOW, 32'hABCD_EF12);
        rd_check("R2 low", A_LOW, 32'h00CD_EF12);
        wr(A_MSK, 32'hFFFF_FFFF);
        rd_check("R2 mask", A_MSK, 32'h7);
        rd_check("R2 unmapped", 8'h18, 32'h0);
        @(negedge clk);
        wr(A_MSK, 32'h0);

        // R3 R4 R5 sweeps
        for (int per = 0; per < 6; per++)
            for (int low = 0; low < 8; low++)
                for (int pol = 0; pol < 2; pol++)
                    run_cfg(0, per, low, pol, 2 * (per + 1));
        for (int per = 0; per < 3; per++)
            for (int low = 0; low < 5; low++)
                run_cfg(1, per, low, low & 1, 2 * (per + 1) * 16);
        run_cfg(2, 1, 1, 0, 4 * 256);
        run_cfg(3, 1, 1, 1, 4 * 2048);

        // R6 low-width write on the wrap edge
        wr(A_CTRL, 0); wr(A_PER, 3); wr(A_LOW, 1); wr(A_CTRL, 2);
        repeat (3) @(negedge clk);
        wr(A_LOW, 3);
        addr = A_CNT;
        for (int k = 4; k < 12; k++) begin
            logic e;
            e = ((k % 4) < ((k < 8) ? 1 : 3)) ? 1'b0 : 1'b1;
            #1;
            check("R6 shadow timing", {31'b0, pwm_out}, {31'b0, e});
            @(negedge clk);
        end

        // R7 period write while running
        wr(A_PER, 9);
        rd_check("R7 period readback", A_PER, 3);
        addr = A_CNT;
        for (int k = 13; k < 21; k++) begin
            #1;
            check("R7 counter keeps period", rdata, k % 4);
            @(negedge clk);
        end

        // R8 disable and restart
        wr(A_CTRL, 0);
        #1;
        check("R8 off output", {31'b0, pwm_out}, 0);
        @(negedge clk);
        rd_check("R8 off counter", A_CNT, 0);
        wr(A_LOW, 2);
        wr(A_CTRL, 2);
        addr = A_CNT;
        for (int k = 0; k < 4; k++) begin
            #1;
            check("R8 restart counter", rdata, k);
            check("R8 restart width", {31'b0, pwm_out}, (k < 2) ? 0 : 1);
            @(negedge clk);
        end

        // R9 clear in the same cycle as a wrap
        wr(A_CTRL, 0); wr(A_PER, 3); wr(A_LOW, 1); wr(A_CTRL, 2);
        repeat (3) @(negedge clk);
        wr(A_STS, 7);
        rd_check("R9 wrap survives clear", A_STS, 32'h4);
        @(negedge clk);
        rd_check("R9 fall flagged", A_STS, 32'h6);
        wr(A_STS, 7);
        rd_check("R9 clear then rise", A_STS, 32'h1);

        // R10 mask gating
        wr(A_CTRL, 0);
        @(negedge clk);
        wr(A_MSK, 4);
        wr(A_STS, 7);
        #1;
        check("R10 irq after clear", {31'b0, irq}, 0);
        wr(A_PER, 1); wr(A_LOW, 0); wr(A_CTRL, 2);
        #1;
        check("R10 k0", {31'b0, irq}, 0);
        @(negedge clk); #1;
        check("R10 rise unmasked only", {31'b0, irq}, 0);
        @(negedge clk); #1;
        check("R10 wrap masked in", {31'b0, irq}, 1);
        @(negedge clk);
        wr(A_MSK, 0);
        #1;
        check("R10 mask off", {31'b0, irq}, 0);
        @(negedge clk);
        wr(A_MSK, 1);
        #1;
        check("R10 rise mask", {31'b0, irq}, 1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule